// File: doc/BRIEF.md
# Stopwatch with Lap Hold

This block is a synchronous stopwatch with two active-low push buttons and a free-running system clock. The mode button steps the stopwatch through a fixed cycle of three modes: cleared, running and stopped. While the stopwatch is running, a prescaler produces a one-cycle count tick every `TICK_DIV` clock cycles. Each tick advances a chain of decimal digit counters. Every digit wraps from nine to zero and carries into the next digit, so the design needs no divide or modulo logic to split the time into digits.

The lap button copies the live time into a separate set of lap registers and toggles which value the display shows. The display decodes the live digits or the lap digits into active-low seven-segment patterns, one group of seven bits per digit. Both buttons are sampled on the system clock and are never used as clocks. A press is the cycle in which a button goes from high to low, so holding a button down does not repeat the action. Debouncing is expected to happen before this block.

Top module: `lap_stopwatch`

## Requirements
- R1: After reset, `mode_oh` is 3'b001 (cleared), `lap_view` is 0 and every digit of the display shows zero.
- R2: `mode_oh` is one-hot, with bit 0 meaning cleared, bit 1 running and bit 2 stopped. Each accepted mode press moves cleared to running, running to stopped, and stopped to cleared.
- R3: A press is accepted at the first clock edge at which the button is low after having been high at the previous edge. Holding the button low for any number of cycles gives exactly one press, and releasing it has no effect.
- R4: While running, the live time increases by one for every `TICK_DIV` clock edges spent in the running mode. The prescaler keeps its phase through the stopped mode and is zeroed in the cleared mode.
- R5: Every digit is BCD and wraps from 9 to 0, carrying one into the next higher digit. The top digit also wraps, so with two digits 09 becomes 10 and 99 becomes 00.
- R6: In the stopped mode the live time holds its value.
- R7: While the mode is cleared, the live digits and the lap digits are forced to zero at each clock edge, `lap_view` is forced to 0, and lap presses are ignored.
- R8: A lap press in the running or stopped mode copies the live time as it stood before that edge into the lap registers. A tick on the same edge is not included in the copy. The press also toggles `lap_view`.
- R9: When `lap_view` is 1 the display shows the lap digits; otherwise it shows the live digits. Digit k (k=0 is least significant) drives `seg_n[7k+6:7k]`.
- R10: The segment code is active-low, with bit 6 = g down to bit 0 = a. The codes for 0 through 9 are 7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00 and 7'h10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_btn_n | input | 1 | Active-low mode button |
| lap_btn_n | input | 1 | Active-low lap button |
| mode_oh | output | 3 | One-hot mode: bit 0 cleared, bit 1 running, bit 2 stopped |
| lap_view | output | 1 | 1 when the display shows the lap value |
| seg_n | output | DIGITS*7 | Active-low segment patterns, digit 0 in the low bits |

## Verification
A lap press can land on the same edge as a count tick, and that tick may also ripple a carry through the digits. The block must capture the value from before the increment while the live time steps forward. The bench provokes this directly: it waits until the prescaler phase is one short of a tick and presses the lap button in that cycle. Random lap presses also fall on tick edges from time to time. The bench judges each case by comparing the decoded lap display against the elapsed running-edge count as it stood before that edge, divided by the tick period.

// File: rtl/sw_pkg.sv
package sw_pkg;
   localparam int SEG_W  = 7;
   localparam int DIG_W  = 4;
   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] MODE_CLR  = 3'b001;
   localparam logic [MODE_W-1:0] MODE_RUN  = 3'b010;
   localparam logic [MODE_W-1:0] MODE_STOP = 3'b100;

   // Active-low pattern, bit 6 = g ... bit 0 = a; non-decimal codes blank.
   function automatic logic [SEG_W-1:0] seg_encode(input logic [DIG_W-1:0] d);
      logic [SEG_W-1:0] s;
      case (d)
         4'd0:    s = 7'b1000000;
         4'd1:    s = 7'b1111001;
         4'd2:    s = 7'b0100100;
         4'd3:    s = 7'b0110000;
         4'd4:    s = 7'b0011001;
         4'd5:    s = 7'b0010010;
         4'd6:    s = 7'b0000010;
         4'd7:    s = 7'b1111000;
         4'd8:    s = 7'b0000000;
         4'd9:    s = 7'b0010000;
         default: s = 7'b1111111;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/sw_press_detect.sv
module sw_press_detect #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] btn_n,
   output logic [N-1:0] press
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= btn_n;
   end

   for (genvar i = 0; i < N; i++) begin : g_btn
      assign press[i] = prev_q[i] & ~btn_n[i];
   end
endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
   parameter int DIV = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   if (DIV == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clr)  cnt_q <= '0;
         else if (run)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign tick = run && (cnt_q == LAST);
   end
endmodule

// File: rtl/sw_bcd_chain.sv
module sw_bcd_chain
   import sw_pkg::*;
#(
   parameter int DIGITS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    step,
   output logic [DIGITS*DIG_W-1:0] value
);
   logic [DIGITS:0] carry;
   assign carry[0] = step;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [DIG_W-1:0] d_q;
      logic             at_nine;
      assign at_nine      = (d_q == DIG_W'(9));
      assign carry[i+1]   = carry[i] & at_nine;
      assign value[i*DIG_W +: DIG_W] = d_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clr) d_q <= '0;
         else if (carry[i]) d_q <= at_nine ? '0 : d_q + 1'b1;
      end
   end
endmodule

// File: rtl/sw_seg_decode.sv
module sw_seg_decode
   import sw_pkg::*;
#(
   parameter int DIGITS = 4
) (
   input  logic [DIGITS*DIG_W-1:0] bcd,
   output logic [DIGITS*SEG_W-1:0] seg_n
);
   for (genvar i = 0; i < DIGITS; i++) begin : g_seg
      assign seg_n[i*SEG_W +: SEG_W] = seg_encode(bcd[i*DIG_W +: DIG_W]);
   end
endmodule

// File: rtl/lap_stopwatch.sv
module lap_stopwatch
   import sw_pkg::*;
#(
   parameter int DIGITS   = 4,
   parameter int TICK_DIV = 500000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_btn_n,
   input  logic                    lap_btn_n,
   output logic [2:0]              mode_oh,
   output logic                    lap_view,
   output logic [DIGITS*7-1:0]     seg_n
);
   localparam int TW = DIGITS * DIG_W;

   initial begin
      assert (DIGITS >= 1) else $error("DIGITS must be at least 1");
      assert (TICK_DIV >= 1) else $error("TICK_DIV must be at least 1");
   end

   logic [1:0]    press;
   logic          mode_press, lap_press, tick;
   logic [2:0]    mode_q;
   logic [TW-1:0] live_bcd, lap_bcd, shown_bcd;
   logic          view_q, in_clr;

   sw_press_detect #(.N(2)) u_press (
      .clk(clk), .rst_n(rst_n),
      .btn_n({lap_btn_n, mode_btn_n}),
      .press(press)
   );
   assign mode_press = press[0];
   assign lap_press  = press[1];

   always_ff @(posedge clk) begin
      if (!rst_n)          mode_q <= MODE_CLR;
      else if (mode_press) mode_q <= {mode_q[1:0], mode_q[2]};
   end
   assign in_clr = mode_q[0];

   sw_prescaler #(.DIV(TICK_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n),
      .run(mode_q[1]), .clr(in_clr),
      .tick(tick)
   );

   sw_bcd_chain #(.DIGITS(DIGITS)) u_time (
      .clk(clk), .rst_n(rst_n),
      .clr(in_clr), .step(tick),
      .value(live_bcd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || in_clr) begin
         lap_bcd <= '0;
         view_q  <= 1'b0;
      end else if (lap_press) begin
         lap_bcd <= live_bcd;
         view_q  <= ~view_q;
      end
   end

   assign shown_bcd = view_q ? lap_bcd : live_bcd;

   sw_seg_decode #(.DIGITS(DIGITS)) u_seg (
      .bcd(shown_bcd),
      .seg_n(seg_n)
   );

   assign mode_oh  = mode_q;
   assign lap_view = view_q;
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
   parameter int DIGITS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mode_press,
   input logic                lap_press,
   input logic                tick,
   input logic [2:0]          mode_oh,
   input logic                lap_view,
   input logic [DIGITS*4-1:0] live_bcd,
   input logic [DIGITS*4-1:0] lap_bcd
);
   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_oh) == 1);

   assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_press |=> mode_oh == {$past(mode_oh[1:0]), $past(mode_oh[2])});

   assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_press |=> $stable(mode_oh));

   assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_press |=> !mode_press);

   assert_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_oh[2] |-> !tick);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !mode_oh[0]) |=> $stable(live_bcd));

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_oh[0] |=> (live_bcd == '0 && lap_bcd == '0 && !lap_view));

   assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lap_press && !mode_oh[0]) |=> lap_bcd == $past(live_bcd));
endmodule

bind lap_stopwatch sw_checker #(.DIGITS(DIGITS)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mode_press(mode_press), .lap_press(lap_press), .tick(tick),
   .mode_oh(mode_oh), .lap_view(lap_view),
   .live_bcd(live_bcd), .lap_bcd(lap_bcd)
);

// File: tb/lap_stopwatch_tb.sv
`timescale 1ns/1ps
module lap_stopwatch_tb;
   localparam int DIGITS = 2;
   localparam int DIV    = 3;
   localparam int MODULO = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_btn_n = 1'b1;
   logic lap_btn_n = 1'b1;
   logic [2:0]          mode_oh;
   logic                lap_view;
   logic [DIGITS*7-1:0] seg_n;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [2:0] exp_mode = 3'b001;
   bit         exp_show = 0;
   int         exp_lap  = 0;
   int         run_edges = 0;
   int         base = 0;

   lap_stopwatch #(.DIGITS(DIGITS), .TICK_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .mode_btn_n(mode_btn_n), .lap_btn_n(lap_btn_n),
      .mode_oh(mode_oh), .lap_view(lap_view), .seg_n(seg_n)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk)
      if (rst_n && exp_mode == 3'b010) run_edges <= run_edges + 1;

   function automatic logic [6:0] seg_of(input int d);
      case (d)
         0: return 7'h40;  1: return 7'h79;  2: return 7'h24;
         3: return 7'h30;  4: return 7'h19;  5: return 7'h12;
         6: return 7'h02;  7: return 7'h78;  8: return 7'h00;
         default: return 7'h10;
      endcase
   endfunction

   function automatic int cur_time();
      return ((run_edges - base) / DIV) % MODULO;
   endfunction

   function automatic logic [13:0] seg_val(input int v);
      return {seg_of((v / 10) % 10), seg_of(v % 10)};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(input string req);
      int shown;
      shown = exp_show ? exp_lap : cur_time();
      chk(mode_oh == exp_mode, {req, " mode"}, int'(mode_oh), int'(exp_mode));
      chk(lap_view == exp_show, {req, " lap_view"}, int'(lap_view), int'(exp_show));
      chk(seg_n == seg_val(shown), {req, " display"}, int'(seg_n), int'(seg_val(shown)));
   endtask

   // called right after a negedge
   task automatic press_mode(input int hold);
      mode_btn_n = 1'b0;
      @(posedge clk); #1;
      exp_mode = {exp_mode[1:0], exp_mode[2]};
      if (exp_mode == 3'b001) begin
         base = run_edges; exp_lap = 0; exp_show = 0;
      end
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(mode_oh == exp_mode, "R3 held press advances once", int'(mode_oh), int'(exp_mode));
      end
      mode_btn_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(mode_oh == exp_mode, "R3 release no effect", int'(mode_oh), int'(exp_mode));
      check_all("R2/R4/R7");
   endtask

   task automatic press_lap(input int hold);
      lap_btn_n = 1'b0;
      if (exp_mode != 3'b001) begin
         exp_lap  = cur_time();
         exp_show = ~exp_show;
      end
      for (int i = 0; i < hold; i++) @(negedge clk);
      lap_btn_n = 1'b1;
      @(negedge clk);
      check_all("R8/R9");
   endtask

   initial begin
      #(5 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int r;
      r = $urandom(32'h1234_5eed);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R10 code for zero
      check_all("R1");
      chk(seg_n[6:0] == 7'b1000000, "R10 zero code", int'(seg_n[6:0]), 7'h40);

      // R2 rotation through all modes
      press_mode(1);
      chk(mode_oh == 3'b010, "R2 cleared->running", int'(mode_oh), 3'b010);
      press_mode(4);
      chk(mode_oh == 3'b100, "R2 running->stopped", int'(mode_oh), 3'b100);
      repeat (10) @(negedge clk);
      check_all("R6 stopped holds");
      press_mode(7);
      chk(mode_oh == 3'b001, "R2 stopped->cleared", int'(mode_oh), 3'b001);
      press_lap(2);
      chk(lap_view == 1'b0, "R7 lap ignored while cleared", int'(lap_view), 0);

      // R5 rollover 09->10 and 99->00
      press_mode(1);
      while (cur_time() != 9) @(negedge clk);
      check_all("R5 at 09");
      chk(seg_n == {7'h40, 7'h10}, "R10 code for 09", int'(seg_n), int'({7'h40, 7'h10}));
      while (cur_time() != 10) @(negedge clk);
      check_all("R5 09->10");
      while (cur_time() != 99) @(negedge clk);
      check_all("R5 at 99");
      while (cur_time() != 0) @(negedge clk);
      check_all("R5 99->00");
      chk(seg_n == {7'h40, 7'h40}, "R5 wrap display", int'(seg_n), int'({7'h40, 7'h40}));

      // R8 lap press on a tick edge
      while (((run_edges - base) % DIV) != DIV - 1) @(negedge clk);
      press_lap(1);
      chk(lap_view == 1'b1, "R8 lap shown", int'(lap_view), 1);
      repeat (8) @(negedge clk);
      check_all("R9 lap held while live runs");
      press_lap(3);
      chk(lap_view == 1'b0, "R9 second lap press returns to live", int'(lap_view), 0);

      // random mix
      for (int it = 0; it < 250; it++) begin
         int act;
         act = $urandom % 8;
         if (act < 3) begin
            repeat (1 + $urandom % 30) @(negedge clk);
            check_all("R4/R6/R9 random wait");
         end else if (act < 5) begin
            press_mode(1 + $urandom % 5);
         end else begin
            press_lap(1 + $urandom % 4);
         end
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule